// File: doc/BRIEF.md
# Bank-Stratified Reorder Buffer

This block is a 32-entry reorder buffer built as four banks of eight entries each. The bank is chosen by the two low bits of the destination register number. Each bank has its own issue lane, so up to four instructions can enter in one cycle. The lane for bank `b` always places its instruction in bank `b`. Within a cycle, a lower lane number means older in program order. An accepted instruction receives a 5-bit tag. The two low bits of the tag are the bank number and the three high bits are the slot inside that bank. The low bits of the tag therefore always match the low bits of the destination register.

Execution units send completions back by tag. The buffer retires instructions in global program order across all banks, using a sequence number taken at allocation. It retires at most one entry per bank per cycle and stops at the first entry that is not yet complete. A rename stage can ask for the youngest pending producer of a source register. Only the bank selected by the register's low bits is searched. Each entry keeps just six key bits: the register-file select bit plus register bits 6..2. A bank that holds eight live entries stalls its own lane, while the other lanes continue. A flush empties the whole buffer in one cycle.

Top module: `strat_rob`

## Requirements
- R1: In the cycle after reset, `alloc_ready` is 4'b1111, `commit_valid` is 0, `lk_hit` is 0 and every lane's `alloc_tag` shows slot 0.
- R2: The tag offered on lane `b` is `{slot[2:0], b[1:0]}`. When the lane accepts an instruction (`alloc_valid[b]` and `alloc_ready[b]`), the slot of bank `b` advances by one, wrapping from 7 back to 0.
- R3: `alloc_ready[b]` is low exactly while bank `b` holds eight live entries. An `alloc_valid[b]` raised while the lane is not ready is ignored and changes no tag.
- R4: A `cmp_valid` pulse with tag `t` marks live entry `t` complete. From the next cycle on, that entry no longer hits in a lookup and may retire.
- R5: Commit retires entries in allocation order. Lower lanes are older within a cycle. `commit_valid[b]`/`commit_tag` name the entry leaving bank `b`. At most one entry leaves each bank per cycle, and retirement stops at the oldest entry that is not complete.
- R6: A lookup of `{lk_is_fp, lk_reg}` searches only bank `lk_reg[1:0]` for live, not-complete entries whose key is `{is_fp, reg[6:2]}`. `lk_hit` reports a match and `lk_tag` gives the youngest matching entry.
- R7: While `flush` is high, no instruction is accepted and nothing commits. In the following cycle every bank is empty: all lanes are ready and the tags are back at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empties the buffer |
| alloc_valid | input | 4 | Per-lane allocation request |
| alloc_is_fp | input | 4 | Per-lane destination register file select |
| alloc_reg | input | 28 | Per-lane 7-bit destination register number, lane b at [7b+6:7b] |
| alloc_ready | output | 4 | Per-lane bank has a free slot |
| alloc_tag | output | 20 | Per-lane tag offered for allocation, lane b at [5b+4:5b] |
| cmp_valid | input | 1 | Completion pulse |
| cmp_tag | input | 5 | Tag of the completed entry |
| commit_valid | output | 4 | Per-bank retirement this cycle |
| commit_tag | output | 20 | Per-bank tag being retired |
| lk_is_fp | input | 1 | Lookup register file select |
| lk_reg | input | 7 | Lookup register number |
| lk_hit | output | 1 | A pending producer exists |
| lk_tag | output | 5 | Tag of the youngest pending producer |

## Verification
The bench fills one bank to eight entries while the other banks stay empty. A design with a shared occupancy count or an off-by-one full test would either admit a ninth entry there or stall every lane. Two instructions that target the same register go into the same bank, so the lookup result shows whether the youngest producer wins or an older one leaks through. Random traffic finishes entries out of order and pushes several same-cycle allocations into one bank's commit chain. A commit stage that skips past an incomplete entry, or retires two entries from one bank in one cycle, would produce a `commit_valid` pattern that differs from the model. Flushes are placed in the middle of a full-bank stall to confirm that every pointer is cleared and that nothing commits in the flush cycle.

// File: rtl/srob_pkg.sv
package srob_pkg;

    localparam int NUM_BANKS  = 4;
    localparam int BANK_DEPTH = 8;
    localparam int REG_NUM_W  = 7;

    localparam int BANK_SEL_W = $clog2(NUM_BANKS);
    localparam int SLOT_W     = $clog2(BANK_DEPTH);
    localparam int TAG_W      = SLOT_W + BANK_SEL_W;
    localparam int KEY_W      = 1 + REG_NUM_W - BANK_SEL_W;
    localparam int SEQ_W      = $clog2(NUM_BANKS * BANK_DEPTH) + 1;
    localparam int CNT_W      = $clog2(BANK_DEPTH + 1);

    typedef logic [KEY_W-1:0] key_t;
    typedef logic [SEQ_W-1:0] seq_t;
    typedef logic [SLOT_W-1:0] slot_t;

    typedef struct packed {
        logic valid;
        logic done;
        key_t key;
        seq_t seq;
    } rob_entry_t;

    function automatic key_t make_key(input logic is_fp, input logic [REG_NUM_W-1:0] rnum);
        return {is_fp, rnum[REG_NUM_W-1:BANK_SEL_W]};
    endfunction

endpackage

// File: rtl/srob_bank.sv
module srob_bank
    import srob_pkg::*;
#(
    parameter int DEPTH = BANK_DEPTH
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  logic  alloc_en,
    input  key_t  alloc_key,
    input  seq_t  alloc_seq,
    output slot_t tail_slot,
    output logic  ready,
    input  logic  cmp_en,
    input  slot_t cmp_slot,
    input  logic  retire_en,
    output logic  head_valid,
    output logic  head_done,
    output seq_t  head_seq,
    output slot_t head_slot,
    input  key_t  lk_key,
    output logic  lk_hit,
    output slot_t lk_slot
);
    localparam int LCNT_W = $clog2(DEPTH + 1);

    rob_entry_t          ent [DEPTH];
    slot_t               head_q;
    slot_t               tail_q;
    logic [LCNT_W-1:0]   cnt_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ent[i] <= '0;
            end
        end else begin
            if (cmp_en) begin
                ent[cmp_slot].done <= 1'b1;
            end
            if (alloc_en) begin
                ent[tail_q] <= '{valid: 1'b1, done: 1'b0, key: alloc_key, seq: alloc_seq};
                tail_q      <= tail_q + 1'b1;
            end
            if (retire_en) begin
                ent[head_q].valid <= 1'b0;
                head_q            <= head_q + 1'b1;
            end
            cnt_q <= cnt_q + LCNT_W'(alloc_en) - LCNT_W'(retire_en);
        end
    end

    assign tail_slot  = tail_q;
    assign head_slot  = head_q;
    assign ready      = (cnt_q != LCNT_W'(DEPTH));
    assign head_valid = ent[head_q].valid;
    assign head_done  = ent[head_q].done;
    assign head_seq   = ent[head_q].seq;

    // Scan from oldest to youngest; the last match is the youngest producer.
    always_comb begin
        slot_t idx;
        lk_hit  = 1'b0;
        lk_slot = '0;
        for (int o = 0; o < DEPTH; o++) begin
            idx = head_q + slot_t'(o);
            if (ent[idx].valid && !ent[idx].done && ent[idx].key == lk_key) begin
                lk_hit  = 1'b1;
                lk_slot = idx;
            end
        end
    end

endmodule

// File: rtl/srob_commit_sel.sv
module srob_commit_sel
    import srob_pkg::*;
#(
    parameter int NB = NUM_BANKS
) (
    input  logic [NB-1:0]            head_valid,
    input  logic [NB-1:0]            head_done,
    input  logic [NB-1:0][SEQ_W-1:0] head_seq,
    input  seq_t                     commit_seq,
    output logic [NB-1:0]            retire,
    output seq_t                     n_retire
);
    // Walk program order from the oldest outstanding sequence number; each
    // step needs the next sequence number complete at the head of some bank.
    always_comb begin
        logic          go;
        logic [NB-1:0] hitk;
        retire   = '0;
        n_retire = '0;
        go       = 1'b1;
        for (int k = 0; k < NB; k++) begin
            for (int b = 0; b < NB; b++) begin
                hitk[b] = head_valid[b] && head_done[b] &&
                          (head_seq[b] == seq_t'(commit_seq + seq_t'(k)));
            end
            if (go && (hitk != '0)) begin
                retire   = retire | hitk;
                n_retire = n_retire + 1'b1;
            end else begin
                go = 1'b0;
            end
        end
    end

endmodule

// File: rtl/strat_rob.sv
module strat_rob
    import srob_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           flush,
    input  logic [NUM_BANKS-1:0]           alloc_valid,
    input  logic [NUM_BANKS-1:0]           alloc_is_fp,
    input  logic [NUM_BANKS*REG_NUM_W-1:0] alloc_reg,
    output logic [NUM_BANKS-1:0]           alloc_ready,
    output logic [NUM_BANKS*TAG_W-1:0]     alloc_tag,
    input  logic                           cmp_valid,
    input  logic [TAG_W-1:0]               cmp_tag,
    output logic [NUM_BANKS-1:0]           commit_valid,
    output logic [NUM_BANKS*TAG_W-1:0]     commit_tag,
    input  logic                           lk_is_fp,
    input  logic [REG_NUM_W-1:0]           lk_reg,
    output logic                           lk_hit,
    output logic [TAG_W-1:0]               lk_tag
);
    localparam int NB = NUM_BANKS;

    logic [NB-1:0]              acc;
    logic [NB-1:0][SEQ_W-1:0]   lane_seq;
    seq_t                       acc_cnt;
    seq_t                       alloc_ctr_q;
    seq_t                       commit_ctr_q;
    seq_t                       n_retire;
    logic [NB-1:0]              retire_raw;
    logic [NB-1:0]              retire;
    logic [NB-1:0][SLOT_W-1:0]  tail_slot;
    logic [NB-1:0][SLOT_W-1:0]  head_slot;
    logic [NB-1:0][SLOT_W-1:0]  bank_lk_slot;
    logic [NB-1:0]              bank_lk_hit;
    logic [NB-1:0]              head_valid;
    logic [NB-1:0]              head_done;
    logic [NB-1:0][SEQ_W-1:0]   head_seq;
    key_t                       lk_key;
    logic [BANK_SEL_W-1:0]      lk_bank;

    assign acc    = alloc_valid & alloc_ready & {NB{~flush}};
    assign retire = retire_raw & {NB{~flush}};

    // Lower lanes are older: each accepted lane takes the next sequence number.
    always_comb begin
        seq_t run;
        run = '0;
        for (int b = 0; b < NB; b++) begin
            lane_seq[b] = alloc_ctr_q + run;
            if (acc[b]) begin
                run = run + 1'b1;
            end
        end
        acc_cnt = run;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            alloc_ctr_q  <= '0;
            commit_ctr_q <= '0;
        end else begin
            alloc_ctr_q  <= alloc_ctr_q + acc_cnt;
            commit_ctr_q <= commit_ctr_q + n_retire;
        end
    end

    assign lk_key  = make_key(lk_is_fp, lk_reg);
    assign lk_bank = lk_reg[BANK_SEL_W-1:0];

    for (genvar b = 0; b < NB; b++) begin : g_bank
        srob_bank #(.DEPTH(BANK_DEPTH)) u_bank (
            .clk        (clk),
            .rst        (rst),
            .flush      (flush),
            .alloc_en   (acc[b]),
            .alloc_key  (make_key(alloc_is_fp[b], alloc_reg[b*REG_NUM_W +: REG_NUM_W])),
            .alloc_seq  (lane_seq[b]),
            .tail_slot  (tail_slot[b]),
            .ready      (alloc_ready[b]),
            .cmp_en     (cmp_valid && (cmp_tag[BANK_SEL_W-1:0] == BANK_SEL_W'(b))),
            .cmp_slot   (cmp_tag[TAG_W-1:BANK_SEL_W]),
            .retire_en  (retire[b]),
            .head_valid (head_valid[b]),
            .head_done  (head_done[b]),
            .head_seq   (head_seq[b]),
            .head_slot  (head_slot[b]),
            .lk_key     (lk_key),
            .lk_hit     (bank_lk_hit[b]),
            .lk_slot    (bank_lk_slot[b])
        );
        assign alloc_tag[b*TAG_W +: TAG_W]  = {tail_slot[b], BANK_SEL_W'(b)};
        assign commit_tag[b*TAG_W +: TAG_W] = {head_slot[b], BANK_SEL_W'(b)};
    end

    srob_commit_sel #(.NB(NB)) u_commit (
        .head_valid (head_valid),
        .head_done  (head_done),
        .head_seq   (head_seq),
        .commit_seq (commit_ctr_q),
        .retire     (retire_raw),
        .n_retire   (n_retire)
    );

    assign commit_valid = retire;
    assign lk_hit       = bank_lk_hit[lk_bank];
    assign lk_tag       = {bank_lk_slot[lk_bank], lk_bank};

endmodule

// File: rtl/strat_rob_checker.sv
module strat_rob_checker
    import srob_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       flush,
    input logic [NUM_BANKS-1:0]       alloc_valid,
    input logic [NUM_BANKS-1:0]       alloc_ready,
    input logic [NUM_BANKS*TAG_W-1:0] alloc_tag,
    input logic [NUM_BANKS-1:0]       commit_valid
);
    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> (alloc_ready == '1 && commit_valid == '0)); // R1

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> (alloc_ready == '1 && commit_valid == '0)); // R7

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        AST_TAG_ADVANCE: assert property (@(posedge clk) disable iff (rst)
            (alloc_valid[b] && alloc_ready[b] && !flush) |=>
            (alloc_tag[b*TAG_W+BANK_SEL_W +: SLOT_W] ==
             SLOT_W'($past(alloc_tag[b*TAG_W+BANK_SEL_W +: SLOT_W]) + 1'b1))); // R2

        AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (!alloc_ready[b] && !commit_valid[b] && !flush) |=> !alloc_ready[b]); // R3

        AST_STALL_TAG_STABLE: assert property (@(posedge clk) disable iff (rst)
            (!alloc_ready[b] && !commit_valid[b] && !flush) |=>
            $stable(alloc_tag[b*TAG_W +: TAG_W])); // R3
    end

endmodule

bind strat_rob strat_rob_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .flush        (flush),
    .alloc_valid  (alloc_valid),
    .alloc_ready  (alloc_ready),
    .alloc_tag    (alloc_tag),
    .commit_valid (commit_valid)
);

// File: tb/strat_rob_bench.sv
`timescale 1ns/1ps
module strat_rob_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        flush;
    logic [3:0]  alloc_valid;
    logic [3:0]  alloc_is_fp;
    logic [27:0] alloc_reg;
    logic [3:0]  alloc_ready;
    logic [19:0] alloc_tag;
    logic        cmp_valid;
    logic [4:0]  cmp_tag;
    logic [3:0]  commit_valid;
    logic [19:0] commit_tag;
    logic        lk_is_fp;
    logic [6:0]  lk_reg;
    logic        lk_hit;
    logic [4:0]  lk_tag;

    always #2.5 clk = ~clk;

    strat_rob u_strat_rob (.*);

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int m_valid [32];
    int m_done  [32];
    int m_key   [32];
    int m_seq   [32];
    int m_head  [4];
    int m_tail  [4];
    int m_cnt   [4];
    int m_aseq;
    int m_cseq;
    bit last_flush;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int t = 0; t < 32; t++) begin
            m_valid[t] = 0; m_done[t] = 0; m_key[t] = 0; m_seq[t] = 0;
        end
        for (int b = 0; b < 4; b++) begin
            m_head[b] = 0; m_tail[b] = 0; m_cnt[b] = 0;
        end
        m_aseq = 0;
        m_cseq = 0;
    endtask

    task automatic idle_inputs();
        flush = 0; alloc_valid = '0; alloc_is_fp = '0; alloc_reg = '0;
        cmp_valid = 0; cmp_tag = '0; lk_is_fp = 0; lk_reg = '0;
    endtask

    // Inputs are set; compare outputs with the model, then advance one clock.
    task automatic step();
        int eready [4];
        int ret    [4];
        int rtag   [4];
        int used   [4];
        int go, found, bank, best, bestseq, key;
        #1;
        for (int b = 0; b < 4; b++) begin
            eready[b] = (m_cnt[b] < 8) ? 1 : 0;
            chk(last_flush ? "R7" : "R3", "alloc_ready", alloc_ready[b], eready[b]);
            chk(last_flush ? "R7" : "R2", "alloc_tag", alloc_tag[b*5 +: 5], m_tail[b]*4 + b);
            ret[b] = 0; rtag[b] = 0; used[b] = 0;
        end
        go = 1;
        for (int k = 0; k < 4; k++) begin
            found = -1;
            for (int t = 0; t < 32; t++)
                if (m_valid[t] != 0 && m_seq[t] == m_cseq + k) found = t;
            if (go != 0 && found >= 0 && m_done[found] != 0 && used[found % 4] == 0) begin
                ret[found % 4] = 1; rtag[found % 4] = found; used[found % 4] = 1;
            end else go = 0;
        end
        if (flush) for (int b = 0; b < 4; b++) ret[b] = 0;
        for (int b = 0; b < 4; b++) begin
            chk(flush ? "R7" : "R5", "commit_valid", commit_valid[b], ret[b]);
            if (ret[b] != 0) chk("R5", "commit_tag", commit_tag[b*5 +: 5], rtag[b]);
        end
        bank = lk_reg % 4;
        key = lk_is_fp * 32 + (lk_reg >> 2);
        best = -1; bestseq = -1;
        for (int t = 0; t < 32; t++)
            if (t % 4 == bank && m_valid[t] != 0 && m_done[t] == 0 &&
                m_key[t] == key && m_seq[t] > bestseq) begin
                best = t; bestseq = m_seq[t];
            end
        chk("R6", "lk_hit", lk_hit, (best >= 0) ? 1 : 0);
        if (best >= 0) chk("R6", "lk_tag", lk_tag, best);
        @(posedge clk);
        last_flush = flush;
        if (flush) model_clear();
        else begin
            if (cmp_valid && m_valid[cmp_tag] != 0) m_done[cmp_tag] = 1;
            for (int b = 0; b < 4; b++) if (ret[b] != 0) begin
                m_valid[rtag[b]] = 0;
                m_head[b] = (m_head[b] + 1) % 8;
                m_cnt[b]--;
                m_cseq++;
            end
            for (int b = 0; b < 4; b++) if (alloc_valid[b] && eready[b] != 0) begin
                int t;
                t = m_tail[b]*4 + b;
                m_valid[t] = 1; m_done[t] = 0;
                m_key[t] = alloc_is_fp[b] * 32 + (alloc_reg[b*7 +: 7] >> 2);
                m_seq[t] = m_aseq++;
                m_tail[b] = (m_tail[b] + 1) % 8;
                m_cnt[b]++;
            end
        end
        @(negedge clk);
    endtask

    task automatic alloc_one(int lane, int fp, int rnum);
        alloc_valid[lane] = 1'b1;
        alloc_is_fp[lane] = fp[0];
        alloc_reg[lane*7 +: 7] = 7'(rnum);
    endtask

    task automatic random_inputs();
        int r;
        idle_inputs();
        flush = ($urandom % 150 == 0);
        for (int b = 0; b < 4; b++)
            if ($urandom % 3 == 0) alloc_one(b, $urandom % 2, (($urandom % 4) << 2) | b);
        r = $urandom % 32;
        for (int i = 0; i < 32; i++) begin
            int t;
            t = (r + i) % 32;
            if (!cmp_valid && m_valid[t] != 0 && m_done[t] == 0 && $urandom % 4 != 0) begin
                cmp_valid = 1; cmp_tag = 5'(t);
            end
        end
        lk_is_fp = 1'($urandom % 2);
        lk_reg = 7'((($urandom % 4) << 2) | ($urandom % 4));
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        idle_inputs();
        model_clear();
        last_flush = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1: reset state
        chk("R1", "alloc_ready", alloc_ready, 15);
        chk("R1", "commit_valid", commit_valid, 0);
        chk("R1", "lk_hit", lk_hit, 0);
        for (int b = 0; b < 4; b++) chk("R1", "alloc_tag", alloc_tag[b*5 +: 5], b);
        @(negedge clk);

        // R6: two producers of int r8 in bank 0, lookup returns the younger
        idle_inputs(); alloc_one(0, 0, 8); step();
        idle_inputs(); alloc_one(0, 0, 8); step();
        idle_inputs(); lk_reg = 7'd8; #1;
        chk("R6", "youngest lk_tag", lk_tag, 4);
        chk("R6", "lk_hit", lk_hit, 1);
        lk_is_fp = 1; #1;
        chk("R6", "fp lookup misses int entry", lk_hit, 0);
        step();

        // R4: complete the younger first; nothing commits, lookup falls to older
        idle_inputs(); cmp_valid = 1; cmp_tag = 5'd4; step();
        idle_inputs(); lk_reg = 7'd8; #1;
        chk("R4", "lk_tag after completion", lk_tag, 0);
        chk("R4", "no commit past incomplete oldest", commit_valid, 0);
        step();
        idle_inputs(); cmp_valid = 1; cmp_tag = 5'd0; step();
        idle_inputs(); #1;
        chk("R4", "oldest commits once done", commit_valid, 1);
        step();
        idle_inputs(); #1;
        chk("R5", "second bank0 entry next cycle", commit_valid, 1);
        chk("R5", "commit_tag", commit_tag[4:0], 4);
        step();

        // R3: fill bank 1 with eight, the ninth request is refused
        for (int i = 0; i < 9; i++) begin
            idle_inputs(); alloc_one(1, 1, 5); step();
        end
        idle_inputs(); #1;
        chk("R3", "bank1 full", alloc_ready[1], 0);
        chk("R3", "other lanes ready", alloc_ready & 4'b1101, 4'b1101);
        step();

        // R7: flush in the middle of the stall
        idle_inputs(); flush = 1; alloc_one(2, 0, 2); step();
        idle_inputs(); #1;
        chk("R7", "ready after flush", alloc_ready, 15);
        chk("R7", "lane2 tag after flush", alloc_tag[14:10], 2);
        step();

        for (int c = 0; c < 4000; c++) begin
            random_inputs();
            step();
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule